// File: doc/BRIEF.md
# Sequenced Planar-Rotation Matrix Engine

This block computes the memoryless part of an orthogonal two-dimensional state-space filter. It takes one seven-element vector: three horizontal states, then two vertical states, then two inputs. It returns a vector of the same shape: the next horizontal states, the next vertical states and the two outputs. The orthogonal system matrix is not held as coefficients. It is held as an ordered list of planar rotations followed by a diagonal of signs. Each list entry holds an angle and the two element positions that the rotation mixes, and those two positions may be any pair.

A single shift-and-add rotation unit works through the list one entry at a time. It reads the two selected elements from an internal vector register file, rotates them over a fixed number of micro-steps, corrects the gain and writes both back. The last entry in the list is applied first. When the list is exhausted, the selected elements are negated and the result is published with a one-cycle completion pulse. The rotation list is written through a small write port while the engine is idle.

The controller has five states. IDLE waits for `start`. FETCH reads one list entry and pre-conditions its angle. ROTATE runs the micro-steps. WRITE stores the rotated pair and moves to the next lower entry. SIGN applies the signs and raises `done`. The transitions are as follows:
- IDLE→FETCH on an accepted start with a non-zero count.
- IDLE→SIGN on an accepted start with a zero count.
- FETCH→ROTATE always.
- ROTATE→WRITE after the last micro-step.
- WRITE→FETCH while entries remain.
- WRITE→SIGN after entry 0.
- SIGN→IDLE always.

Top module: `rot_seq_engine`

## Requirements
- R1: After reset `busy` and `done` are 0 and `vec_out` is all zeros.
- R2: Element k of `vec_in` and of `vec_out` occupies bits [k*18 +: 18]. Each element is an 18-bit two's complement value with 15 fraction bits. Elements 0–2 are the horizontal states, 3–4 are the vertical states, and 5–6 are the inputs on the way in and the outputs on the way out.
- R3: A list entry (angle φ, positions a, b) updates two elements: v[a] becomes cosφ·v[a] − sinφ·v[b], and v[b] becomes sinφ·v[a] + cosφ·v[b]. The angle is a 16-bit two's complement count of radians scaled by 2^13 and is valid within ±π. The positions are 0-based, lie in 0..6 and are distinct. Each result lies within 64 LSB of the exact value.
- R4: An entry at list address q implements factor R(q+1). A run with count M applies addresses M−1, M−2, …, 0, in that order.
- R5: After the rotations, element k is negated when `sign_mask[k]` is 1 and is passed unchanged when it is 0.
- R6: A `rot_count` above 18 is treated as 18. A count of 0 applies only the signs.
- R7: `busy` rises on the clock edge that accepts `start`. `done` is a one-cycle pulse, raised exactly 18·M+1 cycles after that edge, with `busy` low in the same cycle.
- R8: `start` is ignored while `busy` is high. `vec_in`, `rot_count` and `sign_mask` are sampled only on the accepting edge.
- R9: Writes to the rotation list are ignored while `busy` is high. A write made while idle takes effect from the next run.
- R10: `vec_out` changes only in a cycle in which `done` is high, and it holds the last result until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted only while idle |
| rot_count | input | 5 | Number of list entries to apply (M) |
| sign_mask | input | 7 | Bit k set negates result element k |
| vec_in | input | 126 | Packed input vector, 7 × 18 bits |
| busy | output | 1 | High from the accepting edge until completion |
| done | output | 1 | One-cycle completion pulse |
| vec_out | output | 126 | Packed result vector, 7 × 18 bits |
| tbl_we | input | 1 | Rotation list write strobe |
| tbl_addr | input | 5 | List address to write |
| tbl_angle | input | 16 | Angle in radians × 2^13, two's complement |
| tbl_idx_a | input | 3 | First element position of the entry |
| tbl_idx_b | input | 3 | Second element position of the entry |

## Verification
Every result is due 18·M+1 cycles after the edge that accepts its start: one FETCH, sixteen ROTATE and one WRITE cycle per entry, plus one SIGN cycle. A zero count therefore completes in a single cycle. The driver records the cycle count on the falling edge just before the accepting edge and queues that stamp with the expected vector. The monitor samples `done` and `vec_out` on falling edges, so an exact latency comparison follows from the stamp. A result arriving with nothing queued, such as one caused by a wrongly accepted second start, is reported as a mismatch.

// File: rtl/rse_pkg.sv
package rse_pkg;

    // CORDIC micro-steps per planar rotation
    localparam int ITERS  = 16;
    localparam int ITER_W = $clog2(ITERS);
    // internal angle: fraction bits and total width (covers +-8 rad)
    localparam int ZF     = 21;
    localparam int ZW     = ZF + 4;
    // clocks per list entry: fetch + micro-steps + write-back
    localparam int TG     = ITERS + 2;
    // pi/2 in the internal angle format
    localparam logic signed [ZW-1:0] HALF_PI = ZW'(3294199);
    // 1/CORDIC gain for ITERS steps, 17 fraction bits
    localparam int GAIN_F = 17;
    localparam logic signed [GAIN_F:0] GAIN = (GAIN_F+1)'(79594);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ROTATE,
        ST_WRITE,
        ST_SIGN
    } eng_state_t;

    // atan(2^-k) in the internal angle format
    function automatic logic signed [ZW-1:0] atan_step(input logic [ITER_W-1:0] k);
        logic signed [ZW-1:0] r;
        unique case (k)
            4'd0:    r = ZW'(1647099);
            4'd1:    r = ZW'(972339);
            4'd2:    r = ZW'(513757);
            4'd3:    r = ZW'(260791);
            4'd4:    r = ZW'(130902);
            4'd5:    r = ZW'(65515);
            4'd6:    r = ZW'(32765);
            4'd7:    r = ZW'(16384);
            4'd8:    r = ZW'(8192);
            4'd9:    r = ZW'(4096);
            4'd10:   r = ZW'(2048);
            4'd11:   r = ZW'(1024);
            4'd12:   r = ZW'(512);
            4'd13:   r = ZW'(256);
            4'd14:   r = ZW'(128);
            default: r = ZW'(64);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rse_rot_table.sv
module rse_rot_table #(
    parameter int ANG_W  = 16,
    parameter int EIDX_W = 3,
    parameter int DEPTH  = 18,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [PTR_W-1:0]         wr_addr,
    input  logic signed [ANG_W-1:0]  wr_ang,
    input  logic [EIDX_W-1:0]        wr_a,
    input  logic [EIDX_W-1:0]        wr_b,
    input  logic [PTR_W-1:0]         rd_addr,
    output logic signed [ANG_W-1:0]  rd_ang,
    output logic [EIDX_W-1:0]        rd_a,
    output logic [EIDX_W-1:0]        rd_b
);

    logic signed [ANG_W-1:0] ang_mem [DEPTH];
    logic [EIDX_W-1:0]       a_mem   [DEPTH];
    logic [EIDX_W-1:0]       b_mem   [DEPTH];
    logic                    addr_ok;

    assign addr_ok = ({1'b0, wr_addr} < (PTR_W+1)'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                ang_mem[k] <= '0;
                a_mem[k]   <= '0;
                b_mem[k]   <= '0;
            end
        end else if (wr_en && addr_ok) begin
            ang_mem[wr_addr] <= wr_ang;
            a_mem[wr_addr]   <= wr_a;
            b_mem[wr_addr]   <= wr_b;
        end
    end

    assign rd_ang = ang_mem[rd_addr];
    assign rd_a   = a_mem[rd_addr];
    assign rd_b   = b_mem[rd_addr];

endmodule

// File: rtl/rse_rot_unit.sv
module rse_rot_unit
    import rse_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ANG_W  = 16,
    parameter int GUARD  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      step,
    input  logic [ITER_W-1:0]         iter,
    input  logic signed [DATA_W-1:0]  a_in,
    input  logic signed [DATA_W-1:0]  b_in,
    input  logic signed [ANG_W-1:0]   ang_in,
    output logic signed [DATA_W-1:0]  a_out,
    output logic signed [DATA_W-1:0]  b_out
);

    localparam int CW  = DATA_W + 2 + GUARD;   // headroom for CORDIC growth
    localparam int ASH = ZF - (ANG_W - 3);     // external Q3 angle -> internal
    localparam int OSH = GAIN_F + GUARD;
    localparam int PW  = CW + GAIN_F + 1;
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (OSH - 1);

    logic signed [CW-1:0] xq, yq, xe, ye, x0, y0;
    logic signed [ZW-1:0] zq, zr, z0;
    logic signed [PW-1:0] xp, yp;

    // widen operands and fold the angle into the convergence range
    always_comb begin
        xe = {{2{a_in[DATA_W-1]}}, a_in, {GUARD{1'b0}}};
        ye = {{2{b_in[DATA_W-1]}}, b_in, {GUARD{1'b0}}};
        zr = ZW'(ang_in) <<< ASH;
        if (zr > HALF_PI) begin
            x0 = -ye;
            y0 = xe;
            z0 = zr - HALF_PI;
        end else if (zr < -HALF_PI) begin
            x0 = ye;
            y0 = -xe;
            z0 = zr + HALF_PI;
        end else begin
            x0 = xe;
            y0 = ye;
            z0 = zr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xq <= '0;
            yq <= '0;
            zq <= '0;
        end else if (load) begin
            xq <= x0;
            yq <= y0;
            zq <= z0;
        end else if (step) begin
            if (!zq[ZW-1]) begin
                xq <= xq - (yq >>> iter);
                yq <= yq + (xq >>> iter);
                zq <= zq - atan_step(iter);
            end else begin
                xq <= xq + (yq >>> iter);
                yq <= yq - (xq >>> iter);
                zq <= zq + atan_step(iter);
            end
        end
    end

    // gain correction with rounding, then drop guard bits
    always_comb begin
        xp = (PW'(xq) * PW'(GAIN) + RND) >>> OSH;
        yp = (PW'(yq) * PW'(GAIN) + RND) >>> OSH;
    end

    assign a_out = DATA_W'(xp);
    assign b_out = DATA_W'(yp);

endmodule

// File: rtl/rot_seq_engine.sv
module rot_seq_engine
    import rse_pkg::*;
#(
    parameter  int DATA_W = 18,
    parameter  int ANG_W  = 16,
    parameter  int N_ELEM = 7,
    parameter  int DEPTH  = 18,
    localparam int EIDX_W = $clog2(N_ELEM),
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int VEC_W  = N_ELEM * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CNT_W-1:0]     rot_count,
    input  logic [N_ELEM-1:0]    sign_mask,
    input  logic [VEC_W-1:0]     vec_in,
    output logic                 busy,
    output logic                 done,
    output logic [VEC_W-1:0]     vec_out,
    input  logic                 tbl_we,
    input  logic [PTR_W-1:0]     tbl_addr,
    input  logic [ANG_W-1:0]     tbl_angle,
    input  logic [EIDX_W-1:0]    tbl_idx_a,
    input  logic [EIDX_W-1:0]    tbl_idx_b
);

    eng_state_t st_q, st_d;

    logic [PTR_W-1:0]          ptr_q;
    logic [ITER_W-1:0]         it_q;
    logic signed [DATA_W-1:0]  elem_q [N_ELEM];
    logic signed [DATA_W-1:0]  in_elem [N_ELEM];
    logic [N_ELEM-1:0]         flip_q;
    logic [VEC_W-1:0]          out_q;
    logic [VEC_W-1:0]          sgn_vec;
    logic                      done_q;
    logic                      accept;
    logic [CNT_W-1:0]          cnt_eff;

    logic signed [ANG_W-1:0]   tab_ang;
    logic [EIDX_W-1:0]         tab_a, tab_b;
    logic signed [DATA_W-1:0]  rot_a, rot_b;

    assign accept  = start && (st_q == ST_IDLE);
    assign cnt_eff = (rot_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : rot_count;

    // unpack input, apply signs to the working vector
    for (genvar g = 0; g < N_ELEM; g++) begin : g_elem
        assign in_elem[g] = vec_in[g*DATA_W +: DATA_W];
        assign sgn_vec[g*DATA_W +: DATA_W] = flip_q[g] ? -elem_q[g] : elem_q[g];
    end

    rse_rot_table #(
        .ANG_W (ANG_W),
        .EIDX_W(EIDX_W),
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we && (st_q == ST_IDLE)),
        .wr_addr(tbl_addr),
        .wr_ang (tbl_angle),
        .wr_a   (tbl_idx_a),
        .wr_b   (tbl_idx_b),
        .rd_addr(ptr_q),
        .rd_ang (tab_ang),
        .rd_a   (tab_a),
        .rd_b   (tab_b)
    );

    rse_rot_unit #(
        .DATA_W(DATA_W),
        .ANG_W (ANG_W)
    ) u_rot (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (st_q == ST_FETCH),
        .step  (st_q == ST_ROTATE),
        .iter  (it_q),
        .a_in  (elem_q[tab_a]),
        .b_in  (elem_q[tab_b]),
        .ang_in(tab_ang),
        .a_out (rot_a),
        .b_out (rot_b)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = (cnt_eff == '0) ? ST_SIGN : ST_FETCH;
            ST_FETCH:  st_d = ST_ROTATE;
            ST_ROTATE: if (it_q == ITER_W'(ITERS - 1)) st_d = ST_WRITE;
            ST_WRITE:  st_d = (ptr_q == '0) ? ST_SIGN : ST_FETCH;
            ST_SIGN:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            it_q   <= '0;
            flip_q <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
            for (int k = 0; k < N_ELEM; k++) elem_q[k] <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                for (int k = 0; k < N_ELEM; k++) elem_q[k] <= in_elem[k];
                flip_q <= sign_mask;
                ptr_q  <= PTR_W'(cnt_eff - CNT_W'(1));
            end
            unique case (st_q)
                ST_FETCH:  it_q <= '0;
                ST_ROTATE: it_q <= it_q + ITER_W'(1);
                ST_WRITE: begin
                    elem_q[tab_a] <= rot_a;
                    elem_q[tab_b] <= rot_b;
                    ptr_q         <= ptr_q - PTR_W'(1);
                end
                ST_SIGN: begin
                    out_q  <= sgn_vec;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy    = (st_q != ST_IDLE);
    assign done    = done_q;
    assign vec_out = out_q;

endmodule

// File: rtl/rse_chk.sv
module rse_chk
    import rse_pkg::*;
#(
    parameter int DEPTH = 18,
    parameter int CNT_W = 5,
    parameter int VEC_W = 126
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] rot_count,
    input logic             busy,
    input logic             done,
    input logic [VEC_W-1:0] vec_out
);

    logic [15:0]      lat_cnt, lat_exp;
    logic [CNT_W-1:0] eff;

    assign eff = (rot_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : rot_count;

    // cycles since the accepting edge, and the due latency of that run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt <= '0;
            lat_exp <= '0;
        end else if (start && !busy) begin
            lat_cnt <= '0;
            lat_exp <= 16'(eff) * 16'(TG) + 16'd1;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 16'd1;
        end
    end

    a_r7_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6 clamp and R8 no-restart both show up as a latency mismatch
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == lat_exp));

    a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vec_out) |-> done);

endmodule

bind rot_seq_engine rse_chk #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W),
    .VEC_W(VEC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rot_count(rot_count),
    .busy     (busy),
    .done     (done),
    .vec_out  (vec_out)
);

// File: tb/tb_rot_seq_engine.sv
`timescale 1ns/1ps
module tb_rot_seq_engine;

    localparam int W  = 18;
    localparam int N  = 7;
    localparam int D  = 18;
    localparam int VW = N * W;
    localparam int TOL = 64;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, tbl_we = 1'b0;
    logic [4:0]    rot_count = '0, tbl_addr = '0;
    logic [6:0]    sign_mask = '0;
    logic [VW-1:0] vec_in = '0;
    logic [15:0]   tbl_angle = '0;
    logic [2:0]    tbl_a = '0, tbl_b = '0;
    logic          busy, done;
    logic [VW-1:0] vec_out;

    rot_seq_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rot_count(rot_count),
        .sign_mask(sign_mask), .vec_in(vec_in), .busy(busy), .done(done),
        .vec_out(vec_out), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_angle(tbl_angle), .tbl_idx_a(tbl_a), .tbl_idx_b(tbl_b)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  n_chk = 0, n_bad = 0;
    bit  finished = 1'b0;

    real m_ang[D];
    int  m_a[D], m_b[D];

    real   exp_q[$];
    int    tol_q[$], lat_q[$], st_q[$];
    string tag_q[$];

    real va[N] = '{0.6, -0.4, 0.3, -0.2, 0.5, 0.1, -0.35};
    real vb[N] = '{-0.25, 0.45, 0.15, 0.55, -0.3, 0.2, 0.4};
    real vc[N] = '{0.05, 0.2, -0.6, 0.3, 0.1, -0.45, 0.25};

    function automatic int qz(real r);
        if (r >= 0.0) return $rtoi(r * 32768.0 + 0.5);
        else          return -$rtoi(-r * 32768.0 + 0.5);
    endfunction

    function automatic int qa(real r);
        if (r >= 0.0) return $rtoi(r * 8192.0 + 0.5);
        else          return -$rtoi(-r * 8192.0 + 0.5);
    endfunction

    task automatic check_int(input string tag, input int act, input int expv, input int tol);
        int diff;
        n_chk++;
        diff = act - expv;
        if (diff > tol || diff < -tol) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, expv, tol);
        end
    endtask

    // write one list entry; the model follows only if the engine should take it (R9)
    task automatic wr_ent(input int addr, input real ang, input int a, input int b, input bit take);
        int code;
        code = qa(ang);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 5'(addr); tbl_angle = 16'(code);
        tbl_a = 3'(a); tbl_b = 3'(b);
        @(negedge clk);
        tbl_we = 1'b0;
        if (take) begin
            m_ang[addr] = real'(code) / 8192.0;
            m_a[addr] = a;
            m_b[addr] = b;
        end
    endtask

    // driver: compute expected result, queue it, pulse start
    task automatic push_run(input real v[N], input int cnt, input logic [6:0] mask,
                            input int tol, input string tag);
        real w[N];
        real ca, sa, ta, tb;
        int  eff, c;
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            c = qz(v[k]);
            vec_in[k*W +: W] = W'(c);
            w[k] = real'(c) / 32768.0;
        end
        eff = (cnt > D) ? D : cnt;                     // R6 clamp
        for (int k = eff - 1; k >= 0; k--) begin       // R4 order: high address first
            ca = $cos(m_ang[k]); sa = $sin(m_ang[k]);
            ta = w[m_a[k]]; tb = w[m_b[k]];
            w[m_a[k]] = ca * ta - sa * tb;             // R3 rotation
            w[m_b[k]] = sa * ta + ca * tb;
        end
        for (int k = 0; k < N; k++) begin
            if (mask[k]) w[k] = -w[k];                 // R5 signs
            exp_q.push_back(w[k]);
        end
        tol_q.push_back(tol);
        lat_q.push_back(eff * D + 1);                  // R7: 18*M+1
        tag_q.push_back(tag);
        st_q.push_back(cyc);
        rot_count = 5'(cnt); sign_mask = mask; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (eff != 0) check_int({tag, " busy after accept (R7)"}, int'(busy), 1, 0);
    endtask

    task automatic wait_idle();
        while (tag_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pop and compare on every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (tag_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R8 unexpected done: actual 1 expected 0");
            end else begin
                string tag;
                int tol, lat, s, act;
                real e;
                tag = tag_q.pop_front(); tol = tol_q.pop_front();
                lat = lat_q.pop_front(); s = st_q.pop_front();
                check_int({tag, " latency (R7)"}, cyc - s - 1, lat, 0);
                check_int({tag, " busy low with done (R7)"}, int'(busy), 0, 0);
                for (int k = 0; k < N; k++) begin
                    e = exp_q.pop_front();
                    act = $signed(vec_out[k*W +: W]);
                    check_int($sformatf("%s elem %0d (R2)", tag, k), act, qz(e), tol);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] held;
        repeat (3) @(negedge clk);
        check_int("R1 busy in reset", int'(busy), 0, 0);
        check_int("R1 done in reset", int'(done), 0, 0);
        check_int("R1 vec_out zero", int'(vec_out != '0), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 busy after reset", int'(busy), 0, 0);

        // R5/R6: zero count applies signs only, exactly
        push_run(va, 0, 7'b1010011, 0, "R5 signs only");
        wait_idle();

        // R3: single rotation by pi/2
        wr_ent(0, 1.5708, 0, 1, 1'b1);
        push_run(va, 1, 7'b0, TOL, "R3 quarter turn");
        wait_idle();

        // R4: two non-commuting rotations sharing element 1
        wr_ent(0, 0.7, 0, 1, 1'b1);
        wr_ent(1, -1.1, 1, 2, 1'b1);
        push_run(vb, 2, 7'b0, TOL, "R4 order");
        wait_idle();

        // R3: angles beyond +-pi/2 in both directions
        wr_ent(0, 3.0, 3, 6, 1'b1);
        wr_ent(1, -2.6, 5, 2, 1'b1);
        wr_ent(2, -3.1, 4, 0, 1'b1);
        push_run(vc, 3, 7'b0000100, TOL, "R3 wide angles");
        wait_idle();

        // full list with arbitrary pairs
        for (int k = 0; k < D; k++) begin
            int a, b;
            a = k % 7; b = (3 * k + 1) % 7;
            if (a == b) b = (a + 1) % 7;
            wr_ent(k, real'(((k * 37 + 11) % 50) - 25) * 0.12, a, b, 1'b1);
        end
        push_run(va, 17, 7'b0100101, TOL, "R4 seventeen entries");
        wait_idle();

        // R6: count above the depth clamps to 18
        push_run(vb, 25, 7'b0, TOL, "R6 count clamp");
        wait_idle();

        // R8: second start and changed inputs while busy are ignored
        push_run(vc, 2, 7'b0000001, TOL, "R8 first run");
        repeat (6) @(negedge clk);
        vec_in = '1; rot_count = 5'd0; sign_mask = 7'h7f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (40) @(negedge clk);
        check_int("R8 idle after ignored start", int'(busy), 0, 0);

        // R10: result holds after done
        held = vec_out;
        repeat (10) @(negedge clk);
        check_int("R10 vec_out holds", int'(vec_out == held), 1, 0);

        // R9: write while busy ignored, write while idle taken
        push_run(vb, 4, 7'b0, TOL, "R9 run during write");
        wr_ent(0, 2.2, 6, 5, 1'b0);
        wait_idle();
        push_run(va, 1, 7'b0, TOL, "R9 entry kept");
        wait_idle();
        wr_ent(0, -0.9, 2, 4, 1'b1);
        push_run(va, 1, 7'b1000000, TOL, "R9 idle write taken");
        wait_idle();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule